// File: doc/BRIEF.md
# Multiphase Sample Edge Decoder

This block turns the multiphase samples of one detector channel into edge events. In every clock cycle a time bin arrives as two 4-bit words. One word holds the samples taken on the rising clock edge by four evenly spaced clock phases. The other holds the samples taken by the same phases on the falling edge. Together they give eight ordered samples per clock, so one clock splits into eight sub-bins. The block finds the first change of level in each bin and names the bin as no signal, leading edge, signal on or trailing edge. For an edge it gives a 3-bit fine code, which is the sub-bin where the new level is first seen.

A capture window is walked bin by bin. A start strobe marks the first bin of a window and sets the bin index to zero. The block keeps the last sample of the previous bin, so an edge that falls exactly on a bin boundary is still found. Each edge bin also produces a compact hit record holding the edge type, the bin index and the fine code. A downstream stage adds a preset delay to the bin index to get the hit time, and it can collect several hits from one window. A bin that holds more than one change breaks the spacing rules the block relies on. Such a bin sets an error flag and reports only its first change.

Top module: `phase_edge_decoder`

## Requirements
- R1: The eight samples of a bin are ordered by position 0 to 7. Positions 0 to 3 are bits 0 to 3 of `rise_smp_i`, and positions 4 to 7 are bits 0 to 3 of `fall_smp_i`. Bit i is phase i, and phase 0 is the earliest.
- R2: Outputs are registered with a latency of one cycle. `out_valid_o` equals `bin_valid_i` of the previous cycle. While `out_valid_o` is low, `class_o`, `fine_o`, `bin_o`, `multi_err_o`, `hit_valid_o` and `hit_rec_o` are all zero.
- R3: `class_o` encodes 0 = no signal, 1 = leading edge, 2 = signal on, 3 = trailing edge. A bin with no change of level is class 2 if its samples are 1 and class 0 if they are 0.
- R4: The predecessor of position 0 is the sample at position 7 of the last valid bin. Cycles with `bin_valid_i` low leave it unchanged. A bin accepted with `start_i` high uses a predecessor of 0.
- R5: The fine code is the lowest position whose sample differs from its predecessor. A rise there gives class 1 and a fall gives class 3. The fine code is 0 for bins of class 0 or 2.
- R6: A bin accepted with `start_i` high gets bin index 0. Each later valid bin gets the previous index plus 1, wrapping from 63 to 0. `start_i` has no effect while `bin_valid_i` is low.
- R7: A bin with two or more changes of level sets `multi_err_o`. Its class and fine code come from the first change.
- R8: `hit_valid_o` is high only for output bins of class 1 or 3. `hit_rec_o` holds the edge type in bit 9 (1 = trailing), the bin index in bits 8:3 and the fine code in bits 2:0.
- R9: While reset is asserted, all outputs are zero, and the bin counter and the stored predecessor are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bin_valid_i | input | 1 | A time bin is present on the sample inputs |
| start_i | input | 1 | The present bin is the first bin of a window |
| rise_smp_i | input | 4 | Phase samples taken on the rising edge |
| fall_smp_i | input | 4 | Phase samples taken on the falling edge |
| out_valid_o | output | 1 | A decoded bin is present on the outputs |
| class_o | output | 2 | Bin classification |
| fine_o | output | 3 | Sub-bin position of the edge |
| bin_o | output | 6 | Bin index within the window |
| multi_err_o | output | 1 | The bin held more than one change of level |
| hit_valid_o | output | 1 | `hit_rec_o` holds an edge record |
| hit_rec_o | output | 10 | Edge type, bin index and fine code |

## Verification
The assertions check on every cycle that the decoded outputs agree with one another. They cover the one-cycle latency of the valid flag, zero outputs while idle, a zero fine code for bins without an edge, a hit record whose fields match the separate outputs, an error that only comes with an edge, and index zero after a start. Only the bench's scenarios can show that the class and fine code are right for a given sample pattern. The same holds for edges exactly on bin boundaries, the predecessor kept across gaps and cleared by a start, and the index wrap after 64 bins. The bench checks these against pulse timings that it draws at random with a fixed seed.

// File: rtl/phase_edge_pkg.sv
package phase_edge_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_LEAD  = 2'd1,
        CLS_ON    = 2'd2,
        CLS_TRAIL = 2'd3
    } bin_class_e;

endpackage

// File: rtl/ped_sample_order.sv
// Interleaves the rising- and falling-edge phase words into one time-ordered vector.
module ped_sample_order #(
    parameter int NPH = 4,
    localparam int NS = 2 * NPH
) (
    input  logic [NPH-1:0] rise_i,
    input  logic [NPH-1:0] fall_i,
    output logic [NS-1:0]  smp_o
);
    for (genvar i = 0; i < NPH; i++) begin : g_order
        assign smp_o[i]       = rise_i[i];
        assign smp_o[NPH + i] = fall_i[i];
    end
endmodule

// File: rtl/ped_trans_scan.sv
// Finds level changes along the ordered samples, seeded by the previous bin's last sample.
module ped_trans_scan #(
    parameter int NS = 8,
    localparam int FW = $clog2(NS)
) (
    input  logic [NS-1:0] smp_i,
    input  logic          pred_i,
    output logic          any_o,
    output logic          multi_o,
    output logic          rise_o,
    output logic [FW-1:0] first_o
);
    logic [NS-1:0] diff;

    for (genvar k = 0; k < NS; k++) begin : g_diff
        if (k == 0) begin : g_head
            assign diff[k] = smp_i[0] ^ pred_i;
        end else begin : g_body
            assign diff[k] = smp_i[k] ^ smp_i[k-1];
        end
    end

    always_comb begin
        first_o = '0;
        for (int k = NS - 1; k >= 0; k--) begin
            if (diff[k]) first_o = FW'(k);
        end
    end

    assign any_o   = |diff;
    assign multi_o = |(diff & (diff - NS'(1)));
    assign rise_o  = smp_i[first_o];
endmodule

// File: rtl/phase_edge_decoder.sv
module phase_edge_decoder
    import phase_edge_pkg::*;
#(
    parameter int NPH = 4,
    parameter int BIN_W = 6,
    localparam int NS = 2 * NPH,
    localparam int FW = $clog2(NS),
    localparam int REC_W = 1 + BIN_W + FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bin_valid_i,
    input  logic             start_i,
    input  logic [NPH-1:0]   rise_smp_i,
    input  logic [NPH-1:0]   fall_smp_i,
    output logic             out_valid_o,
    output logic [1:0]       class_o,
    output logic [FW-1:0]    fine_o,
    output logic [BIN_W-1:0] bin_o,
    output logic             multi_err_o,
    output logic             hit_valid_o,
    output logic [REC_W-1:0] hit_rec_o
);
    typedef struct packed {
        logic             vld;
        bin_class_e       cls;
        logic [FW-1:0]    fine;
        logic [BIN_W-1:0] bin;
        logic             err;
        logic             hit;
        logic [REC_W-1:0] rec;
        logic             pred;
        logic [BIN_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic [NS-1:0]    smp;
    logic             pred_cur;
    logic [BIN_W-1:0] bin_cur;
    logic             any_chg, multi_chg, chg_rise;
    logic [FW-1:0]    first_pos;

    ped_sample_order #(.NPH(NPH)) u_order (
        .rise_i (rise_smp_i),
        .fall_i (fall_smp_i),
        .smp_o  (smp)
    );

    assign pred_cur = start_i ? 1'b0 : st_q.pred;
    assign bin_cur  = start_i ? '0 : st_q.cnt;

    ped_trans_scan #(.NS(NS)) u_scan (
        .smp_i   (smp),
        .pred_i  (pred_cur),
        .any_o   (any_chg),
        .multi_o (multi_chg),
        .rise_o  (chg_rise),
        .first_o (first_pos)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.cls  = CLS_NONE;
        st_d.fine = '0;
        st_d.bin  = '0;
        st_d.err  = 1'b0;
        st_d.hit  = 1'b0;
        st_d.rec  = '0;
        if (bin_valid_i) begin
            st_d.vld  = 1'b1;
            st_d.bin  = bin_cur;
            st_d.pred = smp[NS-1];
            st_d.cnt  = bin_cur + BIN_W'(1);
            if (any_chg) begin
                st_d.cls  = chg_rise ? CLS_LEAD : CLS_TRAIL;
                st_d.fine = first_pos;
                st_d.err  = multi_chg;
                st_d.hit  = 1'b1;
                st_d.rec  = {~chg_rise, bin_cur, first_pos};
            end else begin
                st_d.cls = smp[0] ? CLS_ON : CLS_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign class_o     = st_q.cls;
    assign fine_o      = st_q.fine;
    assign bin_o       = st_q.bin;
    assign multi_err_o = st_q.err;
    assign hit_valid_o = st_q.hit;
    assign hit_rec_o   = st_q.rec;
endmodule

// File: rtl/ped_checker.sv
module ped_checker #(
    parameter int NPH = 4,
    parameter int BIN_W = 6,
    localparam int NS = 2 * NPH,
    localparam int FW = $clog2(NS),
    localparam int REC_W = 1 + BIN_W + FW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bin_valid_i,
    input logic             start_i,
    input logic             out_valid_o,
    input logic [1:0]       class_o,
    input logic [FW-1:0]    fine_o,
    input logic [BIN_W-1:0] bin_o,
    input logic             multi_err_o,
    input logic             hit_valid_o,
    input logic [REC_W-1:0] hit_rec_o
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == $past(bin_valid_i));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (class_o == 2'd0 && !hit_valid_o && !multi_err_o && bin_o == '0));

    p_level_fine_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !class_o[0]) |-> (fine_o == '0 && !multi_err_o));

    p_start_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i && bin_valid_i) |-> bin_o == '0);

    p_err_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err_o |-> hit_valid_o);

    p_hit_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_o == (out_valid_o && class_o[0]));

    p_rec_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_o |-> (hit_rec_o == {class_o[1], bin_o, fine_o}));
endmodule

bind phase_edge_decoder ped_checker #(.NPH(NPH), .BIN_W(BIN_W)) u_ped_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bin_valid_i (bin_valid_i),
    .start_i     (start_i),
    .out_valid_o (out_valid_o),
    .class_o     (class_o),
    .fine_o      (fine_o),
    .bin_o       (bin_o),
    .multi_err_o (multi_err_o),
    .hit_valid_o (hit_valid_o),
    .hit_rec_o   (hit_rec_o)
);

// File: tb/phase_edge_decoder_tb.sv
module phase_edge_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bin_valid_i = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] rise_smp_i = '0;
    logic [3:0] fall_smp_i = '0;
    logic       out_valid_o;
    logic [1:0] class_o;
    logic [2:0] fine_o;
    logic [5:0] bin_o;
    logic       multi_err_o;
    logic       hit_valid_o;
    logic [9:0] hit_rec_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [511:0] sig;
    int exp_cls [64];
    int exp_fine [64];

    always #10 clk = ~clk;

    phase_edge_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bin_valid_i(bin_valid_i), .start_i(start_i),
        .rise_smp_i(rise_smp_i), .fall_smp_i(fall_smp_i), .out_valid_o(out_valid_o),
        .class_o(class_o), .fine_o(fine_o), .bin_o(bin_o), .multi_err_o(multi_err_o),
        .hit_valid_o(hit_valid_o), .hit_rec_o(hit_rec_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input int vld, input int cls,
                             input int fine, input int bin, input int err);
        int edge_bin;
        int rec;
        edge_bin = (vld != 0 && (cls == 1 || cls == 3)) ? 1 : 0;
        rec = edge_bin ? (((cls == 3) ? 512 : 0) + bin * 8 + fine) : 0;
        chk(int'(out_valid_o) == vld, {req, " valid"}, int'(out_valid_o), vld);
        chk(int'(class_o) == cls, {req, " class"}, int'(class_o), cls);
        chk(int'(fine_o) == fine, {req, " fine"}, int'(fine_o), fine);
        chk(int'(bin_o) == bin, {req, " bin"}, int'(bin_o), bin);
        chk(int'(multi_err_o) == err, {req, " err"}, int'(multi_err_o), err);
        chk(int'(hit_valid_o) == edge_bin, {req, " hit_valid"}, int'(hit_valid_o), edge_bin);
        chk(int'(hit_rec_o) == rec, {req, " hit_rec"}, int'(hit_rec_o), rec);
    endtask

    // Drives one cycle of inputs after a falling edge; returns at the next falling edge.
    task automatic step(input bit st, input bit v, input logic [3:0] r, input logic [3:0] f);
        start_i = st;
        bin_valid_i = v;
        rise_smp_i = r;
        fall_smp_i = f;
        @(negedge clk);
    endtask

    // Builds a random pulse train: widths and gaps above one clock (8 sub-bins).
    task automatic build_window();
        int t;
        int e;
        sig = '0;
        for (int b = 0; b < 64; b++) begin
            exp_cls[b] = 0;
            exp_fine[b] = 0;
        end
        t = int'($urandom % 40);
        while (t < 500) begin
            e = t + 9 + int'($urandom % 60);
            if (e > 511) break;
            for (int k = t; k < e; k++) sig[k] = 1'b1;
            exp_cls[t / 8] = 1;
            exp_fine[t / 8] = t % 8;
            exp_cls[e / 8] = 3;
            exp_fine[e / 8] = e % 8;
            t = e + 9 + int'($urandom % 60);
        end
        for (int b = 0; b < 64; b++) begin
            if (exp_cls[b] == 0 && sig[8 * b]) exp_cls[b] = 2;
        end
    endtask

    initial begin
        #200000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        step(1'b1, 1'b1, 4'hF, 4'hF);
        // R9: outputs stay cleared while reset is held, even with a bin on the inputs
        check_out("R9 reset", 0, 0, 0, 0, 0);
        step(1'b0, 1'b0, 4'h0, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R2 idle", 0, 0, 0, 0, 0);

        // R1 R3 R5 R8: random pulse windows, each bin compared against pulse timing
        for (int w = 0; w < 6; w++) begin
            build_window();
            for (int b = 0; b < 64; b++) begin
                step(b == 0, 1'b1, sig[8*b +: 4], sig[8*b+4 +: 4]);
                check_out("R5 random bin", 1, exp_cls[b], exp_fine[b], b, 0);
            end
        end
        step(1'b0, 1'b0, 4'h0, 4'h0);
        check_out("R2 gap", 0, 0, 0, 0, 0);

        // R1: one sample at a time in the fall word gives fine code 4..7
        for (int p = 0; p < 4; p++) begin
            step(1'b1, 1'b1, 4'h0, 4'(4'hF << p));
            check_out("R1 fall order", 1, 1, 4 + p, 0, 0);
        end

        // R7: rise at position 1, fall at position 3 -> leading, fine 1, error
        step(1'b1, 1'b1, 4'b0110, 4'b0000);
        check_out("R7 multi", 1, 1, 1, 0, 1);
        step(1'b0, 1'b1, 4'h0, 4'h0);
        check_out("R7 clean after", 1, 0, 0, 1, 0);

        // R4: predecessor held across invalid cycles; start ignored while invalid (R6)
        step(1'b0, 1'b1, 4'hF, 4'hF);
        check_out("R4 rise at boundary", 1, 1, 0, 2, 0);
        step(1'b1, 1'b0, 4'h0, 4'h0);
        check_out("R6 start without valid", 0, 0, 0, 0, 0);
        step(1'b0, 1'b0, 4'h0, 4'h0);
        step(1'b0, 1'b1, 4'hF, 4'hF);
        check_out("R4 held predecessor", 1, 2, 0, 3, 0);
        step(1'b0, 1'b1, 4'h0, 4'h0);
        check_out("R4 fall at boundary", 1, 3, 0, 4, 0);
        step(1'b0, 1'b1, 4'hF, 4'hF);
        check_out("R4 rise again", 1, 1, 0, 5, 0);

        // R4: start clears the predecessor, so a high bin is a leading edge
        step(1'b1, 1'b1, 4'hF, 4'hF);
        check_out("R4 start clears", 1, 1, 0, 0, 0);

        // R6: index wraps from 63 to 0
        for (int b = 1; b < 64; b++) begin
            step(1'b0, 1'b1, 4'hF, 4'hF);
            check_out("R6 count", 1, 2, 0, b, 0);
        end
        step(1'b0, 1'b1, 4'hF, 4'h7);
        check_out("R6 wrap", 1, 3, 7, 0, 0);
        step(1'b0, 1'b0, 4'h0, 4'h0);
        check_out("R2 final idle", 0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule